// File: doc/BRIEF.md
# Predicated Shifted-Operand Add Unit

This block executes one family of 32-bit add instructions, one instruction per clock. It holds sixteen 32-bit general registers and a four-flag condition register (N, Z, C, V). Each instruction carries a 4-bit predicate that is tested against the current flags. If the predicate fails, the instruction does nothing. The second operand comes in one of three shapes: a 13-bit immediate, a 7-bit immediate shifted left by a 4-bit count, or a register shifted left by a 5-bit count. The shifted shapes can also fold the current carry flag into the sum.

Bits are numbered 0 to 31 from the most significant end, so instruction bit i sits on `instr_word[31-i]`. The destination and first-source register fields stay at fixed positions in every shape, and the immediate is split around them. Any encoding that is not a legal add raises a one-cycle illegal pulse and changes no state. Register contents can be read through a separate combinational test port.

Top module: `padd_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all sixteen registers, the flags and `illegal_o` are cleared to zero. `flags_o` is ordered {N,Z,C,V} from bit 3 down to bit 0.
- R2: Bits 0-3 hold the predicate and bits 4-7 the operation code, which is 0000 for this family. Bit 10 = 0 selects the immediate shape. In that shape, the destination register (bits 11-14) receives the source register (bits 15-18) plus the zero-extended 13-bit value in bits 19-31, at the clock edge where `instr_valid` is high.
- R3: In the shifted shapes (bit 10 = 1), bit 31 = 0 selects the shifted immediate. The 7-bit value is bits 19-23 followed by bits 28-29. It is zero-extended, shifted left by the count in bits 24-27, and added to the source register. Bits pushed out past bit 31 are lost.
- R4: Bit 31 = 1 selects the shifted register. The second source register is in bits 19-22 and is shifted left by the 5-bit count in bits 23-27 before the add.
- R5: In either shifted shape, bit 30 = 1 adds the current C flag as a carry-in.
- R6: Bit 9 = 1 loads the flags from the sum. N is bit 31 of the sum, Z is set when the sum is zero, C is the carry out of bit 31, and V is signed overflow. When bit 9 = 0 the flags are left unchanged.
- R7: The predicate codes 0 to 15 are EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE, AL, NV. A predicate that is not satisfied by the current flags (NV is never satisfied) leaves every register and the flags unchanged.
- R8: A nonzero operation code, bit 8 = 1, or nonzero bits 28-29 in the shifted-register shape make `illegal_o` high for the cycle after the edge where the instruction was taken, and change no register or flag.
- R9: With `instr_valid` low, no register or flag changes and `illegal_o` goes low on the next edge.
- R10: `tp_data` shows the register selected by `tp_addr`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr_word | input | 32 | Instruction word, bit 0 of the format on bit 31 |
| tp_addr | input | 4 | Test-port register select |
| tp_data | output | 32 | Test-port register contents |
| flags_o | output | 4 | Current flags {N,Z,C,V} |
| illegal_o | output | 1 | One-cycle pulse for a rejected encoding |

## Verification
Every cycle, the assertions check these port-level behaviours: the flags hold when flag update is off, when the predicate is NV, and when no instruction is present; a bad operation code or a set bit 8 always produces the illegal pulse with the flags held; and reset clears the flags and the pulse. The arithmetic itself can only be shown by the bench's scenarios. These cover the split-immediate and shifted-operand values, truncation past bit 31, carry-in, carry-out and signed overflow into the flags, and the predicate outcomes against flags built up by earlier instructions. Register contents are read back through the test port after each instruction.

// File: rtl/padd_pkg.sv
package padd_pkg;

    localparam int XLEN     = 32;
    localparam int NREG     = 16;
    localparam int RIDX     = $clog2(NREG);
    localparam int IMM13_W  = 13;
    localparam int IMM7_W   = 7;
    localparam int SHAMT_W  = 5;

    typedef enum logic [3:0] {
        CND_EQ = 4'h0, CND_NE = 4'h1, CND_CS = 4'h2, CND_CC = 4'h3,
        CND_MI = 4'h4, CND_PL = 4'h5, CND_VS = 4'h6, CND_VC = 4'h7,
        CND_HI = 4'h8, CND_LS = 4'h9, CND_GE = 4'hA, CND_LT = 4'hB,
        CND_GT = 4'hC, CND_LE = 4'hD, CND_AL = 4'hE, CND_NV = 4'hF
    } cond_e;

    typedef enum logic [1:0] {
        OPF_IMM13 = 2'd0,
        OPF_SIMM  = 2'd1,
        OPF_SREG  = 2'd2
    } opform_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        cond_e                cond;
        logic                 illegal;
        logic                 set_flags;
        logic                 use_carry;
        opform_e              form;
        logic [RIDX-1:0]      rd;
        logic [RIDX-1:0]      ra;
        logic [RIDX-1:0]      rb;
        logic [IMM13_W-1:0]   imm13;
        logic [IMM7_W-1:0]    imm7;
        logic [SHAMT_W-1:0]   shamt;
    } dec_t;

    function automatic logic cond_pass(input cond_e c, input nzcv_t f);
        logic r;
        case (c)
            CND_EQ:  r = f.z;
            CND_NE:  r = !f.z;
            CND_CS:  r = f.c;
            CND_CC:  r = !f.c;
            CND_MI:  r = f.n;
            CND_PL:  r = !f.n;
            CND_VS:  r = f.v;
            CND_VC:  r = !f.v;
            CND_HI:  r = f.c && !f.z;
            CND_LS:  r = !f.c || f.z;
            CND_GE:  r = (f.n == f.v);
            CND_LT:  r = (f.n != f.v);
            CND_GT:  r = !f.z && (f.n == f.v);
            CND_LE:  r = f.z || (f.n != f.v);
            CND_AL:  r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic nzcv_t sum_flags(input logic [XLEN-1:0] a,
                                        input logic [XLEN-1:0] b,
                                        input logic [XLEN-1:0] s,
                                        input logic            cout);
        nzcv_t f;
        f.n = s[XLEN-1];
        f.z = (s == '0);
        f.c = cout;
        f.v = (a[XLEN-1] == b[XLEN-1]) && (s[XLEN-1] != a[XLEN-1]);
        return f;
    endfunction

endpackage

// File: rtl/padd_decode.sv
module padd_decode
    import padd_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);
    // Format bit i (MSB-first) lives on word[31-i].
    logic [3:0] major;
    logic       pad8;
    logic       shifted;
    logic       sel_reg;
    logic [1:0] mid_pad;

    always_comb begin
        major   = word[27:24];
        pad8    = word[23];
        shifted = word[21];
        sel_reg = word[0];
        mid_pad = word[3:2];

        dec.cond      = cond_e'(word[31:28]);
        dec.set_flags = word[22];
        dec.rd        = word[20:17];
        dec.ra        = word[16:13];
        dec.imm13     = word[12:0];
        dec.use_carry = shifted && word[1];
        dec.imm7      = {word[12:8], word[3:2]};

        if (!shifted) begin
            dec.form  = OPF_IMM13;
            dec.rb    = '0;
            dec.shamt = '0;
        end else if (!sel_reg) begin
            dec.form  = OPF_SIMM;
            dec.rb    = '0;
            dec.shamt = {1'b0, word[7:4]};
        end else begin
            dec.form  = OPF_SREG;
            dec.rb    = word[12:9];
            dec.shamt = word[8:4];
        end

        dec.illegal = (major != 4'h0) || pad8 ||
                      (shifted && sel_reg && (mid_pad != 2'b00));
    end
endmodule

// File: rtl/padd_operand.sv
module padd_operand
    import padd_pkg::*;
(
    input  dec_t            dec,
    input  logic [XLEN-1:0] rb_val,
    input  logic            carry_flag,
    output logic [XLEN-1:0] opnd,
    output logic            cin
);
    logic [XLEN-1:0] base;

    always_comb begin
        case (dec.form)
            OPF_SIMM: base = XLEN'(dec.imm7);
            OPF_SREG: base = rb_val;
            default:  base = XLEN'(dec.imm13);
        endcase
        if (dec.form == OPF_IMM13)
            opnd = base;
        else
            opnd = base << dec.shamt;
        cin = dec.use_carry && carry_flag;
    end
endmodule

// File: rtl/padd_regfile.sv
module padd_regfile #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_b,
    input  logic [AW-1:0]    raddr_t,
    output logic [WIDTH-1:0] rdata_t
);
    logic [WIDTH-1:0] mem [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst)
                    mem[g] <= '0;
                else if (we && (waddr == AW'(g)))
                    mem[g] <= wdata;
            end
        end
    endgenerate

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
    assign rdata_t = mem[raddr_t];
endmodule

// File: rtl/padd_unit.sv
module padd_unit
    import padd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic [31:0]      instr_word,
    input  logic [RIDX-1:0]  tp_addr,
    output logic [XLEN-1:0]  tp_data,
    output logic [3:0]       flags_o,
    output logic             illegal_o
);
    dec_t            dec;
    nzcv_t           flags_q;
    nzcv_t           flags_nx;
    logic [XLEN-1:0] ra_val;
    logic [XLEN-1:0] rb_val;
    logic [XLEN-1:0] opnd;
    logic [XLEN-1:0] sum;
    logic            cin;
    logic            cout;
    logic            go;
    logic            illegal_q;

    padd_decode u_dec (
        .word (instr_word),
        .dec  (dec)
    );

    padd_regfile #(.DEPTH(NREG), .WIDTH(XLEN)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (go),
        .waddr   (dec.rd),
        .wdata   (sum),
        .raddr_a (dec.ra),
        .rdata_a (ra_val),
        .raddr_b (dec.rb),
        .rdata_b (rb_val),
        .raddr_t (tp_addr),
        .rdata_t (tp_data)
    );

    padd_operand u_opnd (
        .dec        (dec),
        .rb_val     (rb_val),
        .carry_flag (flags_q.c),
        .opnd       (opnd),
        .cin        (cin)
    );

    always_comb begin
        {cout, sum} = {1'b0, ra_val} + {1'b0, opnd} + {{XLEN{1'b0}}, cin};
        flags_nx    = sum_flags(ra_val, opnd, sum, cout);
        go          = instr_valid && !dec.illegal && cond_pass(dec.cond, flags_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q   <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= instr_valid && dec.illegal;
            if (go && dec.set_flags)
                flags_q <= flags_nx;
        end
    end

    assign flags_o   = flags_q;
    assign illegal_o = illegal_q;
endmodule

// File: rtl/padd_unit_chk.sv
module padd_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic [31:0] instr_word,
    input logic [3:0]  flags_o,
    input logic        illegal_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (flags_o == 4'h0) && !illegal_o);                       // R1

    AST_FLAGS_HOLD_NOSET: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !instr_word[22]) |=> $stable(flags_o));         // R6

    AST_NV_NOP: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_word[31:28] == 4'hF) |=> $stable(flags_o)); // R7

    AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && (instr_word[27:24] != 4'h0 || instr_word[23]))
            |=> illegal_o && $stable(flags_o));                         // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> !illegal_o && $stable(flags_o));               // R9
endmodule

bind padd_unit padd_unit_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .flags_o     (flags_o),
    .illegal_o   (illegal_o)
);

// File: tb/padd_unit_tb.sv
module padd_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] AL = 4'hE;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [31:0] instr_word;
    logic [3:0]  tp_addr;
    logic [31:0] tp_data;
    logic [3:0]  flags_o;
    logic        illegal_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    padd_unit dut_i (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .tp_addr     (tp_addr),
        .tp_data     (tp_data),
        .flags_o     (flags_o),
        .illegal_o   (illegal_o)
    );

    function automatic logic [31:0] enc_imm(logic [3:0] p, logic f, logic [3:0] rc,
                                            logic [3:0] ra, logic [12:0] imm);
        return {p, 4'h0, 1'b0, f, 1'b0, rc, ra, imm};
    endfunction

    function automatic logic [31:0] enc_simm(logic [3:0] p, logic f, logic k, logic [3:0] rc,
                                             logic [3:0] ra, logic [6:0] imm, logic [3:0] s);
        return {p, 4'h0, 1'b0, f, 1'b1, rc, ra, imm[6:2], s, imm[1:0], k, 1'b0};
    endfunction

    function automatic logic [31:0] enc_sreg(logic [3:0] p, logic f, logic k, logic [3:0] rc,
                                             logic [3:0] ra, logic [3:0] rb, logic [4:0] s,
                                             logic [1:0] pad);
        return {p, 4'h0, 1'b0, f, 1'b1, rc, ra, rb, s, pad, k, 1'b1};
    endfunction

    typedef struct packed {
        logic [31:0] w;
        logic [3:0]  ridx;
        logic [31:0] val;
        logic [3:0]  fl;
        logic        ill;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VEC [NVEC] = '{
        '{enc_imm(AL, 1'b0, 4'd1, 4'd0, 13'd1),                      4'd1,  32'd1,          4'h0, 1'b0}, // R2
        '{enc_imm(AL, 1'b1, 4'd2, 4'd0, 13'h1FFF),                   4'd2,  32'd8191,       4'h0, 1'b0}, // R2 R6
        '{enc_simm(AL, 1'b0, 1'b0, 4'd3, 4'd1, 7'h7F, 4'd4),         4'd3,  32'd2033,       4'h0, 1'b0}, // R3
        '{enc_simm(AL, 1'b0, 1'b0, 4'd4, 4'd0, 7'h7F, 4'd15),        4'd4,  32'h003F8000,   4'h0, 1'b0}, // R3
        '{enc_sreg(AL, 1'b1, 1'b0, 4'd5, 4'd0, 4'd1, 5'd31, 2'b00),  4'd5,  32'h80000000,   4'h8, 1'b0}, // R4 R6
        '{enc_sreg(AL, 1'b1, 1'b0, 4'd6, 4'd5, 4'd5, 5'd0, 2'b00),   4'd6,  32'h0,          4'h7, 1'b0}, // R6 carry+ovf
        '{enc_sreg(AL, 1'b0, 1'b1, 4'd7, 4'd1, 4'd1, 5'd3, 2'b00),   4'd7,  32'd10,         4'h7, 1'b0}, // R5
        '{enc_simm(AL, 1'b1, 1'b1, 4'd8, 4'd0, 7'd1, 4'd0),          4'd8,  32'd2,          4'h0, 1'b0}, // R5 R6
        '{enc_imm(4'h0, 1'b0, 4'd9, 4'd0, 13'd5),                    4'd9,  32'd0,          4'h0, 1'b0}, // R7 EQ fails
        '{enc_imm(4'h1, 1'b0, 4'd9, 4'd0, 13'd5),                    4'd9,  32'd5,          4'h0, 1'b0}, // R7 NE passes
        '{enc_imm(4'hF, 1'b1, 4'd9, 4'd0, 13'd7),                    4'd9,  32'd5,          4'h0, 1'b0}, // R7 NV
        '{enc_imm(AL, 1'b1, 4'd10, 4'd0, 13'd3) | 32'h01000000,      4'd10, 32'd0,          4'h0, 1'b1}, // R8 opcode
        '{enc_imm(AL, 1'b1, 4'd10, 4'd0, 13'd3) | 32'h00800000,      4'd10, 32'd0,          4'h0, 1'b1}, // R8 bit8
        '{enc_sreg(AL, 1'b1, 1'b0, 4'd10, 4'd1, 4'd1, 5'd1, 2'b10),  4'd10, 32'd0,          4'h0, 1'b1}, // R8 pad
        '{enc_sreg(AL, 1'b1, 1'b0, 4'd11, 4'd2, 4'd2, 5'd19, 2'b00), 4'd11, 32'hFFF81FFF,   4'h8, 1'b0}, // R4 R6
        '{enc_imm(4'hB, 1'b0, 4'd12, 4'd0, 13'd9),                   4'd12, 32'd9,          4'h8, 1'b0}, // R7 LT
        '{enc_imm(4'hA, 1'b0, 4'd12, 4'd0, 13'd1),                   4'd12, 32'd9,          4'h8, 1'b0}, // R7 GE fails
        '{enc_imm(4'h4, 1'b0, 4'd13, 4'd0, 13'd3),                   4'd13, 32'd3,          4'h8, 1'b0}  // R7 MI
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        @(negedge clk);
        instr_valid = 1'b0;
        instr_word  = 32'h0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst         = 1'b1;
        instr_valid = 1'b0;
        instr_word  = 32'h0;
        tp_addr     = 4'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        for (int i = 0; i < 16; i++) begin
            tp_addr = 4'(i);
            #1;
            check("R1 reg after reset", tp_data, 32'h0);
        end
        check("R1 flags after reset", {28'h0, flags_o}, 32'h0);
        check("R1 illegal after reset", {31'h0, illegal_o}, 32'h0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i].w);
            tp_addr = VEC[i].ridx;
            #1;
            check($sformatf("R2-table vec%0d R10 reg", i), tp_data, VEC[i].val);
            check($sformatf("R6 vec%0d flags", i), {28'h0, flags_o}, {28'h0, VEC[i].fl});
            check($sformatf("R8 vec%0d illegal", i), {31'h0, illegal_o}, {31'h0, VEC[i].ill});
        end

        // R9: word present but valid low
        @(negedge clk);
        instr_word = enc_imm(AL, 1'b1, 4'd15, 4'd0, 13'd77);
        @(negedge clk);
        instr_word = 32'h0;
        tp_addr = 4'd15;
        #1;
        check("R9 reg untouched", tp_data, 32'h0);
        check("R9 flags untouched", {28'h0, flags_o}, 32'h8);
        check("R9 no illegal", {31'h0, illegal_o}, 32'h0);

        // R8: illegal pulse lasts one cycle
        issue(enc_imm(AL, 1'b0, 4'd14, 4'd0, 13'd1) | 32'h0F000000);
        @(negedge clk);
        check("R8 illegal drops", {31'h0, illegal_o}, 32'h0);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        tp_addr = 4'd11;
        #1;
        check("R1 reg cleared by reset", tp_data, 32'h0);
        check("R1 flags cleared by reset", {28'h0, flags_o}, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule